// File: doc/BRIEF.md
# Match-Mask Chip-Select Address Decoder

This block turns a bus address into a one-hot static-memory chip select. Each select owns an 8-bit match byte and an 8-bit mask byte. The select responds when address bits [31:24] agree with the match byte in every position where the mask bit is 1. A mask bit of 0 turns that match bit into a don't-care, so one select can own several 64MB windows, and those windows need not be contiguous.

Configuration lives in 32-bit registers that each hold the settings for two selects. Software writes them through a single-cycle port made of a write enable, a register index and write data. An address is presented together with a valid strobe. One clock later the decoder gives either exactly one select or a no-hit flag. When several selects hit, a fixed priority resolves it: the lowest-numbered select wins. Any address with a nonzero value in bits [39:32] decodes to no select.

Top module: `cs_window_decoder`

## Requirements
- R1: Register k holds the settings for two selects. For select 2k, bits [31:24] are the match byte and bits [23:16] the mask byte. For select 2k+1, bits [15:8] are the match byte and bits [7:0] the mask byte. Register k is written when cfg_we is 1 and cfg_idx equals k.
- R2: Select i hits when (addr[31:24] & mask_i) == (match_i & mask_i). A mask bit of 1 requires the address bit to equal the match bit. A mask bit of 0 makes that bit a don't-care.
- R3: With match 0x0C and mask 0xFC, a select covers 0x00_0C00_0000 through 0x00_0FFF_FFFF and nothing just outside that range.
- R4: If addr[39:32] is nonzero, no select asserts and no_hit is set. Bits [23:0] of the address never change the decode.
- R5: cs_sel is one-hot or zero. When several selects hit, only the lowest-numbered one is asserted (bit i of cs_sel is select i).
- R6: For a valid address that matches no select, no_hit is 1 and cs_sel is 0. When addr_vld is 0, both cs_sel and no_hit are 0 on the next cycle.
- R7: After reset every match and mask byte is 0xFF. As a result, only addr[31:24] = 0xFF hits, and select 0 wins that address.
- R8: cs_sel and no_hit reflect the address and strobe sampled at the previous clock edge. A configuration write is used for strobes sampled from the next edge onward. A strobe sampled on the same edge as the write still uses the old setting.
- R9: With match 0x00 and mask 0xF4, a select covers both 0x00_0000_0000–0x00_03FF_FFFF and 0x00_0800_0000–0x00_0BFF_FFFF, but not 0x00_0400_0000–0x00_07FF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 2 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| addr | input | 40 | Bus address |
| addr_vld | input | 1 | Address valid strobe |
| cs_sel | output | 8 | Registered one-hot chip select |
| no_hit | output | 1 | Registered flag: valid address matched no select |

## Verification
The bench builds the decoder with its default values: eight selects in four registers and a 40-bit address. With those values, both register halves, every index and the top select (bit 7) can be reached. The tests include overlapping regions, so the lowest-numbered-wins rule is exercised against a higher select that also hits. The 40-bit width lets the bench place addresses where only bits [39:32] are nonzero. The bench probes the edges of contiguous and split windows, and it checks a write that lands on the same edge as a strobe.

// File: rtl/cs_window_decoder.sv
module cs_window_decoder #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 40
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [((NUM_CS/2)>1 ? $clog2(NUM_CS/2) : 1)-1:0] cfg_idx,
  input  logic [31:0]                            cfg_wdata,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic                                   addr_vld,
  output logic [NUM_CS-1:0]                      cs_sel,
  output logic                                   no_hit
);
  localparam int NUM_REGS = NUM_CS / 2;
  localparam int IDX_W    = NUM_REGS > 1 ? $clog2(NUM_REGS) : 1;
  localparam int WIN_LO   = 24;

  logic [7:0]        match_q [NUM_CS];
  logic [7:0]        mask_q  [NUM_CS];
  logic [NUM_CS-1:0] hit, grant;
  logic [7:0]        win;
  logic              upper_zero;
  logic              unused_low;

  assign win        = addr[WIN_LO+7:WIN_LO];
  assign upper_zero = (addr[ADDR_W-1:WIN_LO+8] == '0);
  assign unused_low = ^addr[WIN_LO-1:0];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        match_q[2*k]   <= 8'hFF;
        mask_q[2*k]    <= 8'hFF;
        match_q[2*k+1] <= 8'hFF;
        mask_q[2*k+1]  <= 8'hFF;
      end else if (cfg_we && cfg_idx == IDX_W'(k)) begin
        match_q[2*k]   <= cfg_wdata[31:24];
        mask_q[2*k]    <= cfg_wdata[23:16];
        match_q[2*k+1] <= cfg_wdata[15:8];
        mask_q[2*k+1]  <= cfg_wdata[7:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_hit
    assign hit[i] = upper_zero && (((win ^ match_q[i]) & mask_q[i]) == 8'h00);
  end

  assign grant = hit & (~hit + NUM_CS'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sel <= '0;
      no_hit <= 1'b0;
    end else begin
      cs_sel <= addr_vld ? grant : '0;
      no_hit <= addr_vld && (hit == '0);
    end
  end
endmodule

module cs_window_decoder_chk #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_vld,
  input logic [NUM_CS-1:0] cs_sel,
  input logic              no_hit
);
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    no_hit |-> (cs_sel == '0));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> (cs_sel == '0 && !no_hit));
  p_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> (no_hit != (cs_sel != '0)));
  p_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && addr[ADDR_W-1:32] != '0) |=> no_hit);
endmodule

bind cs_window_decoder cs_window_decoder_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .addr_vld(addr_vld),
  .cs_sel(cs_sel), .no_hit(no_hit));

// File: tb/cs_window_decoder_bench.sv
`timescale 1ns/1ps
module cs_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [39:0] addr = '0;
  logic        addr_vld = 1'b0;
  logic [7:0]  cs_sel;
  logic        no_hit;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cs_window_decoder u_cs_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .addr(addr), .addr_vld(addr_vld),
    .cs_sel(cs_sel), .no_hit(no_hit));

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got cs=%h nh=%b, expected cs=%h nh=%b",
               tag, got[8:1], got[0], exp[8:1], exp[0]);
    end
  endtask

  task automatic write_cfg(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [39:0] a, input logic [7:0] ecs, input logic enh);
    @(negedge clk);
    addr = a; addr_vld = 1'b1;
    @(negedge clk);
    addr_vld = 1'b0;
    check(tag, {cs_sel, no_hit}, {ecs, enh});
  endtask

  task automatic t_reset;
    check("R7 outputs at reset", {cs_sel, no_hit}, 9'h000);
    probe("R7 0xFF byte hits select 0", 40'h00_FF12_3456, 8'h01, 1'b0);
    probe("R7 other byte misses", 40'h00_1000_0000, 8'h00, 1'b1);
  endtask

  task automatic t_window_r3;
    write_cfg(2'd0, 32'h0CFC_FFFF);
    probe("R3 low edge", 40'h00_0C00_0000, 8'h01, 1'b0);
    probe("R3 high edge", 40'h00_0FFF_FFFF, 8'h01, 1'b0);
    probe("R3 below", 40'h00_0BFF_FFFF, 8'h00, 1'b1);
    probe("R3 above", 40'h00_1000_0000, 8'h00, 1'b1);
    probe("R2 mid window", 40'h00_0D80_0000, 8'h01, 1'b0);
  endtask

  task automatic t_split_r9;
    write_cfg(2'd1, 32'h00F4_FFFF);
    probe("R9 first low", 40'h00_0000_0000, 8'h04, 1'b0);
    probe("R9 first high", 40'h00_03FF_FFFF, 8'h04, 1'b0);
    probe("R9 gap low", 40'h00_0400_0000, 8'h00, 1'b1);
    probe("R9 gap high", 40'h00_07FF_FFFF, 8'h00, 1'b1);
    probe("R9 second low", 40'h00_0800_0000, 8'h04, 1'b0);
    probe("R9 second high", 40'h00_0BFF_FFFF, 8'h04, 1'b0);
  endtask

  task automatic t_layout_r1;
    write_cfg(2'd3, 32'h40FF_50FF);
    probe("R1 upper half to select 6", 40'h00_4000_0000, 8'h40, 1'b0);
    probe("R1 lower half to select 7", 40'h00_50AB_CDEF, 8'h80, 1'b0);
  endtask

  task automatic t_upper_r4;
    probe("R4 bit 32 set", 40'h01_0C00_0000, 8'h00, 1'b1);
    probe("R4 bit 39 set", 40'h80_0000_0000, 8'h00, 1'b1);
    probe("R4 low bits ignored", 40'h00_0CFF_FFFF, 8'h01, 1'b0);
  endtask

  task automatic t_priority_r5;
    write_cfg(2'd2, 32'h50F0_FFFF);
    probe("R5 select 4 beats 7", 40'h00_5000_0000, 8'h10, 1'b0);
    probe("R5 select 4 alone", 40'h00_5A00_0000, 8'h10, 1'b0);
  endtask

  task automatic t_idle_r6;
    @(negedge clk);
    addr = 40'h00_0C00_0000; addr_vld = 1'b0;
    @(negedge clk);
    check("R6 no strobe gives nothing", {cs_sel, no_hit}, 9'h000);
    probe("R6 no_hit on miss", 40'h00_3000_0000, 8'h00, 1'b1);
    @(negedge clk);
    check("R6 no_hit clears after strobe", {cs_sel, no_hit}, 9'h000);
  endtask

  task automatic t_timing_r8;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = 32'h20FF_FFFF;
    addr = 40'h00_0C00_0000; addr_vld = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; addr_vld = 1'b0;
    check("R8 same-edge strobe sees old config", {cs_sel, no_hit}, {8'h01, 1'b0});
    probe("R8 new config in force", 40'h00_2000_0000, 8'h01, 1'b0);
    probe("R8 old window gone", 40'h00_0C00_0000, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window_r3();
    t_split_r9();
    t_layout_r1();
    t_upper_r4();
    t_priority_r5();
    t_idle_r6();
    t_timing_r8();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule